// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block holds the programmer-visible registers of a small accumulator CPU and moves data among them. There are two 8-bit accumulators, an 8-bit condition code register, and three 16-bit registers: two index registers and a stack pointer. A 16-bit double accumulator is not separate storage. It is the first accumulator as the high byte joined to the second as the low byte, so a write to it changes both accumulators.

Each cycle the datapath may present one command. A command has an operation, a source code and a destination code, and it takes effect at the next rising clock edge. The operation is a copy, a swap, a sign-extending copy, or a load of a 16-bit value from the datapath. Copies and swaps between registers of different widths follow fixed rules. A narrow-to-wide copy sign-extends. A wide-to-narrow copy keeps the low byte. A mixed swap exchanges the low bytes and clears the high byte of the wide register. The register contents are always visible on the outputs.

Top module: `reg_xfer_unit`

## Requirements
- R1: An asynchronous active-low reset sets every register to zero, except the stack pointer, which takes the value of the SP_RESET parameter (default 0x0000).
- R2: A command is accepted when cmd_valid_i is high at a rising edge, and its result is visible on the outputs after that edge. Operation codes are 0 = copy, 1 = swap, 2 = sign-extending copy, 3 = load. Register codes are 0 = accumulator A, 1 = accumulator B, 2 = condition codes, 3 = reserved, 4 = double accumulator D, 5 = index X, 6 = index Y, 7 = stack pointer. Codes 0 to 2 are 8-bit and codes 4 to 7 are 16-bit.
- R3: A copy between two registers of the same width writes the full source value into the destination.
- R4: A copy from an 8-bit source to a 16-bit destination writes the source into the low byte and fills every bit of the high byte with bit 7 of the source.
- R5: A copy from a 16-bit source to an 8-bit destination writes bits 7:0 of the source.
- R6: A swap between two different registers of the same width exchanges their full contents in one cycle.
- R7: A swap between an 8-bit and a 16-bit register exchanges their low bytes and sets the high byte of the 16-bit register to 0x00. Where the 16-bit register is D, the write to the 8-bit register takes precedence on the byte they share. So swapping A with D gives A = old B and B = old A, and swapping B with D gives A = 0x00 and B = old B.
- R8: A write to D sets A to bits 15:8 and B to bits 7:0 of the written value, and a read of D yields {A, B}.
- R9: The sign-extending copy behaves like a copy when its source is A, B or the condition codes and its destination is D, X, Y or SP. With any other pair it changes nothing.
- R10: No register changes when cmd_valid_i is low, when the destination code is 3, or when the source code is 3 for a copy, swap or sign-extending copy.
- R11: The condition code register changes only when it is the destination of a command or the partner of a swap.
- R12: A swap of a register with itself changes nothing.
- R13: A load writes load_data_i into the destination. An 8-bit destination takes bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Operation code |
| cmd_src_i | input | 3 | Source register code |
| cmd_dst_i | input | 3 | Destination register code |
| load_data_i | input | 16 | Value written by a load |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| ccr_o | output | 8 | Condition code register |
| idx_x_o | output | 16 | Index register X |
| idx_y_o | output | 16 | Index register Y |
| sp_o | output | 16 | Stack pointer |

## Verification
Copies are driven from sources whose bit 7 is set and from sources whose bit 7 is clear. This separates real sign extension from zero padding. Wide sources carry different high and low bytes, which shows whether truncation keeps the correct byte. Swaps are tried between two narrow registers, between two wide registers, between narrow and wide registers in both operand orders, and between an accumulator and D in both orders, where the byte-precedence rule decides the result. A long pseudo-random run of mixed commands, including reserved codes and invalid sign-extend pairs, then compares the visible registers after each edge against a model written in the bench.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned NWR    = 2;  // write ports: destination, swap partner

  typedef enum logic [1:0] {
    OP_TFR  = 2'd0,
    OP_XCHG = 2'd1,
    OP_SEXT = 2'd2,
    OP_LOAD = 2'd3
  } op_e;

  // bit 2 of the code marks a wide register
  typedef enum logic [2:0] {
    RC_A   = 3'd0,
    RC_B   = 3'd1,
    RC_CCR = 3'd2,
    RC_RSV = 3'd3,
    RC_D   = 3'd4,
    RC_X   = 3'd5,
    RC_Y   = 3'd6,
    RC_SP  = 3'd7
  } reg_code_e;

  typedef struct packed {
    logic              en;
    reg_code_e         code;
    logic [WORD_W-1:0] data;
  } wr_port_t;

  function automatic logic [WORD_W-1:0] pick(
    input reg_code_e         c,
    input logic [BYTE_W-1:0] a,
    input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] ccr,
    input logic [WORD_W-1:0] x,
    input logic [WORD_W-1:0] y,
    input logic [WORD_W-1:0] sp
  );
    case (c)
      RC_A:    return {{BYTE_W{1'b0}}, a};
      RC_B:    return {{BYTE_W{1'b0}}, b};
      RC_CCR:  return {{BYTE_W{1'b0}}, ccr};
      RC_D:    return {a, b};
      RC_X:    return x;
      RC_Y:    return y;
      RC_SP:   return sp;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rxu_read_port.sv
module rxu_read_port
  import rxu_pkg::*;
(
  input  reg_code_e         code_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic [BYTE_W-1:0] ccr_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] val_o,
  output logic              wide_o,
  output logic              ok_o
);
  always_comb begin
    val_o  = '0;
    wide_o = 1'b0;
    ok_o   = 1'b1;
    case (code_i)
      RC_A:   val_o = {{BYTE_W{1'b0}}, a_i};
      RC_B:   val_o = {{BYTE_W{1'b0}}, b_i};
      RC_CCR: val_o = {{BYTE_W{1'b0}}, ccr_i};
      RC_D:   begin val_o = {a_i, b_i}; wide_o = 1'b1; end
      RC_X:   begin val_o = x_i;        wide_o = 1'b1; end
      RC_Y:   begin val_o = y_i;        wide_o = 1'b1; end
      RC_SP:  begin val_o = sp_i;       wide_o = 1'b1; end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxu_cmd_plan.sv
module rxu_cmd_plan
  import rxu_pkg::*;
(
  input  logic                  valid_i,
  input  op_e                   op_i,
  input  reg_code_e             src_i,
  input  reg_code_e             dst_i,
  input  logic [WORD_W-1:0]     load_i,
  input  logic [WORD_W-1:0]     src_val_i,
  input  logic                  src_wide_i,
  input  logic                  src_ok_i,
  input  logic [WORD_W-1:0]     dst_val_i,
  input  logic                  dst_wide_i,
  input  logic                  dst_ok_i,
  output wr_port_t [NWR-1:0]    wr_o
);
  logic [WORD_W-1:0] sext_v;
  logic              mixed;
  logic              tfr_ok;

  assign sext_v = {{BYTE_W{src_val_i[BYTE_W-1]}}, src_val_i[BYTE_W-1:0]};
  assign mixed  = src_wide_i ^ dst_wide_i;
  assign tfr_ok = (op_i == OP_TFR) || (!src_wide_i && dst_wide_i);

  always_comb begin
    wr_o = '0;
    if (valid_i && dst_ok_i) begin
      case (op_i)
        OP_LOAD: wr_o[0] = '{en: 1'b1, code: dst_i, data: load_i};
        OP_TFR, OP_SEXT: begin
          if (src_ok_i && tfr_ok)
            wr_o[0] = '{en: 1'b1, code: dst_i,
                        data: src_wide_i ? src_val_i : sext_v};
        end
        OP_XCHG: begin
          if (src_ok_i && (src_i != dst_i)) begin
            // a mixed swap clears the high byte of the wide side
            wr_o[0] = '{en: 1'b1, code: dst_i,
                        data: (mixed && dst_wide_i)
                              ? {{BYTE_W{1'b0}}, src_val_i[BYTE_W-1:0]} : src_val_i};
            wr_o[1] = '{en: 1'b1, code: src_i,
                        data: (mixed && src_wide_i)
                              ? {{BYTE_W{1'b0}}, dst_val_i[BYTE_W-1:0]} : dst_val_i};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxu_regfile.sv
module rxu_regfile
  import rxu_pkg::*;
#(
  parameter logic [WORD_W-1:0] SP_RESET = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  wr_port_t [NWR-1:0]    wr_i,
  output logic [BYTE_W-1:0]     a_o,
  output logic [BYTE_W-1:0]     b_o,
  output logic [BYTE_W-1:0]     ccr_o,
  output logic [WORD_W-1:0]     x_o,
  output logic [WORD_W-1:0]     y_o,
  output logic [WORD_W-1:0]     sp_o
);
  logic [BYTE_W-1:0] a_q, b_q, ccr_q, a_n, b_n, ccr_n;
  logic [WORD_W-1:0] x_q, y_q, sp_q, x_n, y_n, sp_n;

  always_comb begin
    a_n = a_q; b_n = b_q; ccr_n = ccr_q;
    x_n = x_q; y_n = y_q; sp_n = sp_q;
    // wide writes first, then narrow writes override the shared accumulator bytes
    for (int p = 0; p < NWR; p++) begin
      if (wr_i[p].en) begin
        case (wr_i[p].code)
          RC_D: begin
            a_n = wr_i[p].data[WORD_W-1:BYTE_W];
            b_n = wr_i[p].data[BYTE_W-1:0];
          end
          RC_X:    x_n  = wr_i[p].data;
          RC_Y:    y_n  = wr_i[p].data;
          RC_SP:   sp_n = wr_i[p].data;
          default: ;
        endcase
      end
    end
    for (int p = 0; p < NWR; p++) begin
      if (wr_i[p].en) begin
        case (wr_i[p].code)
          RC_A:    a_n   = wr_i[p].data[BYTE_W-1:0];
          RC_B:    b_n   = wr_i[p].data[BYTE_W-1:0];
          RC_CCR:  ccr_n = wr_i[p].data[BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; ccr_q <= '0;
      x_q <= '0; y_q <= '0; sp_q <= SP_RESET;
    end else begin
      a_q <= a_n; b_q <= b_n; ccr_q <= ccr_n;
      x_q <= x_n; y_q <= y_n; sp_q <= sp_n;
    end
  end

  assign a_o = a_q;  assign b_o = b_q;  assign ccr_o = ccr_q;
  assign x_o = x_q;  assign y_o = y_q;  assign sp_o  = sp_q;

  // R1: stack pointer holds its reset value while reset is held
  always_comb if (!rst_ni) AST_SP_RESET: assert (sp_q == SP_RESET); // R1
endmodule

// File: rtl/reg_xfer_unit.sv
module reg_xfer_unit
  import rxu_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [1:0]  cmd_op_i,
  input  logic [2:0]  cmd_src_i,
  input  logic [2:0]  cmd_dst_i,
  input  logic [15:0] load_data_i,
  output logic [7:0]  acc_a_o,
  output logic [7:0]  acc_b_o,
  output logic [7:0]  ccr_o,
  output logic [15:0] idx_x_o,
  output logic [15:0] idx_y_o,
  output logic [15:0] sp_o
);
  localparam int unsigned NRD = 2;  // 0: source, 1: destination

  reg_code_e [NRD-1:0]         rd_code;
  logic [NRD-1:0][WORD_W-1:0]  rd_val;
  logic [NRD-1:0]              rd_wide;
  logic [NRD-1:0]              rd_ok;
  wr_port_t [NWR-1:0]          wr;

  assign rd_code[0] = reg_code_e'(cmd_src_i);
  assign rd_code[1] = reg_code_e'(cmd_dst_i);

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    rxu_read_port u_rd (
      .code_i (rd_code[g]),
      .a_i    (acc_a_o),
      .b_i    (acc_b_o),
      .ccr_i  (ccr_o),
      .x_i    (idx_x_o),
      .y_i    (idx_y_o),
      .sp_i   (sp_o),
      .val_o  (rd_val[g]),
      .wide_o (rd_wide[g]),
      .ok_o   (rd_ok[g])
    );
  end

  rxu_cmd_plan u_plan (
    .valid_i    (cmd_valid_i),
    .op_i       (op_e'(cmd_op_i)),
    .src_i      (rd_code[0]),
    .dst_i      (rd_code[1]),
    .load_i     (load_data_i),
    .src_val_i  (rd_val[0]),
    .src_wide_i (rd_wide[0]),
    .src_ok_i   (rd_ok[0]),
    .dst_val_i  (rd_val[1]),
    .dst_wide_i (rd_wide[1]),
    .dst_ok_i   (rd_ok[1]),
    .wr_o       (wr)
  );

  rxu_regfile #(.SP_RESET(SP_RESET)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .a_o    (acc_a_o),
    .b_o    (acc_b_o),
    .ccr_o  (ccr_o),
    .x_o    (idx_x_o),
    .y_o    (idx_y_o),
    .sp_o   (sp_o)
  );

  logic copy_cmd, no_effect;
  assign copy_cmd  = cmd_valid_i && (cmd_op_i == OP_TFR || cmd_op_i == OP_SEXT) && rd_ok[0] && rd_ok[1];
  assign no_effect = !cmd_valid_i || (cmd_dst_i == RC_RSV) || (cmd_op_i != OP_LOAD && cmd_src_i == RC_RSV);

  AST_SEXT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_cmd && !rd_wide[0] && rd_wide[1]) |=>
    (pick(reg_code_e'($past(cmd_dst_i)), acc_a_o, acc_b_o, ccr_o, idx_x_o, idx_y_o, sp_o)
      == {{BYTE_W{$past(rd_val[0][BYTE_W-1])}}, $past(rd_val[0][BYTE_W-1:0])})); // R4

  AST_TRUNC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_cmd && cmd_op_i == OP_TFR && rd_wide[0] && !rd_wide[1]) |=>
    (pick(reg_code_e'($past(cmd_dst_i)), acc_a_o, acc_b_o, ccr_o, idx_x_o, idx_y_o, sp_o)
      == {{BYTE_W{1'b0}}, $past(rd_val[0][BYTE_W-1:0])})); // R5

  AST_MIXED_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_XCHG && rd_ok[0] && rd_ok[1] && (rd_wide[0] ^ rd_wide[1])
      && cmd_src_i != RC_D && cmd_dst_i != RC_D) |=>
    (pick(reg_code_e'($past(cmd_src_i[2] ? cmd_src_i : cmd_dst_i)),
          acc_a_o, acc_b_o, ccr_o, idx_x_o, idx_y_o, sp_o)[WORD_W-1:BYTE_W] == '0)); // R7

  AST_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_effect |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(ccr_o)
                   && $stable(idx_x_o) && $stable(idx_y_o) && $stable(sp_o))); // R10

  AST_CCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_dst_i != RC_CCR && !(cmd_op_i == OP_XCHG && cmd_src_i == RC_CCR)) |=> $stable(ccr_o)); // R11

  AST_LOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_LOAD && cmd_dst_i[2]) |=>
    (pick(reg_code_e'($past(cmd_dst_i)), acc_a_o, acc_b_o, ccr_o, idx_x_o, idx_y_o, sp_o)
      == $past(load_data_i))); // R13
endmodule

// File: tb/reg_xfer_unit_test.sv
module reg_xfer_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] TFR = 2'd0, XCH = 2'd1, SXT = 2'd2, LDI = 2'd3;
  localparam logic [2:0] CA = 3'd0, CB = 3'd1, CC = 3'd2, CR = 3'd3,
                         CD = 3'd4, CX = 3'd5, CY = 3'd6, CS = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  src = '0, dst = '0;
  logic [15:0] imm = '0;
  logic [7:0]  a_o, b_o, c_o;
  logic [15:0] x_o, y_o, s_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  a, b, c;
    logic [15:0] x, y, s;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0]  m_a = 0, m_b = 0, m_c = 0;
  logic [15:0] m_x = 0, m_y = 0, m_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_xfer_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_src_i(src), .cmd_dst_i(dst), .load_data_i(imm),
    .acc_a_o(a_o), .acc_b_o(b_o), .ccr_o(c_o),
    .idx_x_o(x_o), .idx_y_o(y_o), .sp_o(s_o)
  );

  function automatic logic [15:0] mget(logic [2:0] c);
    case (c)
      CA: return {8'h00, m_a};
      CB: return {8'h00, m_b};
      CC: return {8'h00, m_c};
      CD: return {m_a, m_b};
      CX: return m_x;
      CY: return m_y;
      CS: return m_s;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic mput(logic [2:0] c, logic [15:0] v);
    case (c)
      CA: m_a = v[7:0];
      CB: m_b = v[7:0];
      CC: m_c = v[7:0];
      CD: begin m_a = v[15:8]; m_b = v[7:0]; end
      CX: m_x = v;
      CY: m_y = v;
      CS: m_s = v;
      default: ;
    endcase
  endtask

  task automatic model(logic v, logic [1:0] o, logic [2:0] s, logic [2:0] d, logic [15:0] i);
    logic [15:0] vs, vd, sx;
    logic sw, dw;
    if (!v || d == CR) return;
    if (o == LDI) begin mput(d, i); return; end
    if (s == CR) return;
    vs = mget(s); vd = mget(d);
    sw = s[2]; dw = d[2];
    sx = {{8{vs[7]}}, vs[7:0]};
    if (o == TFR) mput(d, sw ? vs : sx);
    else if (o == SXT) begin
      if (!sw && dw) mput(d, sx);
    end else begin
      if (s == d) return;
      if (sw == dw) begin mput(d, vs); mput(s, vd); end
      else if (sw) begin mput(s, {8'h00, vd[7:0]}); mput(d, vs); end
      else begin mput(d, {8'h00, vs[7:0]}); mput(s, vd); end
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.a = m_a; e.b = m_b; e.c = m_c; e.x = m_x; e.y = m_y; e.s = m_s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmd(logic v, logic [1:0] o, logic [2:0] s, logic [2:0] d,
                     logic [15:0] i, string tag);
    @(negedge clk);
    valid = v; op = o; src = s; dst = d; imm = i;
    model(v, o, s, d, i);
    push(tag);
  endtask

  task automatic compare(exp_t e);
    checks++;
    if ({a_o, b_o, c_o, x_o, y_o, s_o} !== {e.a, e.b, e.c, e.x, e.y, e.s}) begin
      errors++;
      $display("FAIL %s actual a=%h b=%h c=%h x=%h y=%h sp=%h expected a=%h b=%h c=%h x=%h y=%h sp=%h",
               e.tag, a_o, b_o, c_o, x_o, y_o, s_o, e.a, e.b, e.c, e.x, e.y, e.s);
    end
  endtask

  // monitor: one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    e0.a = 0; e0.b = 0; e0.c = 0; e0.x = 0; e0.y = 0; e0.s = 0; e0.tag = "R1 in reset";
    compare(e0);
    @(negedge clk);
    rst_n = 1'b1;
    push("R1 after release");

    cmd(1, LDI, CA, CA, 16'hAA85, "R13 load A low byte");
    cmd(1, LDI, CA, CB, 16'h003C, "R13 load B");
    cmd(1, LDI, CA, CC, 16'h00D1, "R13 load CCR");
    cmd(1, LDI, CA, CX, 16'h1234, "R13 load X");
    cmd(1, LDI, CA, CY, 16'hBEEF, "R13 load Y");
    cmd(1, LDI, CA, CS, 16'h0A00, "R13 load SP");
    cmd(1, LDI, CA, CD, 16'h7F01, "R8 load D splits");
    cmd(1, LDI, CA, CA, 16'h0085, "R13 reload A");
    cmd(1, TFR, CA, CB, 16'h0, "R3 copy A to B");
    cmd(1, TFR, CX, CY, 16'h0, "R3 copy X to Y");
    cmd(1, LDI, CA, CB, 16'h0042, "R13 load B positive");
    cmd(1, TFR, CB, CX, 16'h0, "R4 copy positive byte to X");
    cmd(1, TFR, CA, CS, 16'h0, "R4 copy negative byte to SP");
    cmd(1, TFR, CC, CY, 16'h0, "R4 copy CCR to Y");
    cmd(1, LDI, CA, CY, 16'h5AC3, "R13 load Y");
    cmd(1, TFR, CY, CA, 16'h0, "R5 copy Y low to A");
    cmd(1, TFR, CS, CC, 16'h0, "R5 R11 copy SP low to CCR");
    cmd(1, TFR, CD, CX, 16'h0, "R8 copy D to X");
    cmd(1, TFR, CA, CD, 16'h0, "R8 R4 copy A to D");
    cmd(1, LDI, CA, CB, 16'h00F0, "R13 load B");
    cmd(1, SXT, CB, CY, 16'h0, "R9 sext B to Y");
    cmd(1, SXT, CA, CB, 16'h0, "R9 sext narrow dest ignored");
    cmd(1, SXT, CX, CY, 16'h0, "R9 sext wide source ignored");
    cmd(1, LDI, CA, CA, 16'h0011, "R13 load A");
    cmd(1, XCH, CA, CB, 16'h0, "R6 swap A B");
    cmd(1, LDI, CA, CX, 16'hC0DE, "R13 load X");
    cmd(1, XCH, CX, CS, 16'h0, "R6 swap X SP");
    cmd(1, XCH, CA, CX, 16'h0, "R7 swap A X");
    cmd(1, XCH, CY, CC, 16'h0, "R7 R11 swap Y CCR");
    cmd(1, LDI, CA, CD, 16'h9A7B, "R13 load D");
    cmd(1, XCH, CA, CD, 16'h0, "R7 swap A D");
    cmd(1, LDI, CA, CD, 16'h9A7B, "R13 load D");
    cmd(1, XCH, CD, CB, 16'h0, "R7 swap D B");
    cmd(1, XCH, CX, CX, 16'h0, "R12 swap X with itself");
    cmd(1, XCH, CC, CC, 16'h0, "R12 swap CCR with itself");
    cmd(1, TFR, CR, CX, 16'h0, "R10 reserved source");
    cmd(1, TFR, CX, CR, 16'h0, "R10 reserved destination");
    cmd(1, LDI, CA, CR, 16'hFFFF, "R10 load reserved");
    cmd(0, LDI, CA, CX, 16'hFFFF, "R10 valid low");
    cmd(1, LDI, CA, CC, 16'h0077, "R11 load CCR");
    cmd(1, TFR, CX, CY, 16'h0, "R11 CCR held");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] ro = 2'($urandom_range(0, 3));
      logic [2:0] rs = 3'($urandom_range(0, 7));
      logic [2:0] rd = 3'($urandom_range(0, 7));
      logic rv = ($urandom_range(0, 7) != 0);
      cmd(rv, ro, rs, rd, 16'($urandom), "R2 mixed sequence");
    end

    @(negedge clk);
    valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule